// File: doc/BRIEF.md
# VLIW Packet Word Framer

The framer takes 32-bit instruction words one per handshake and gathers them into a packet. Bits [15:14] of each word, the parse field, decide what the word is. A word with parse field 11 closes the packet as a normal word. A word with parse field 00 is a duplex: it carries two 13-bit sub-instructions and also closes the packet. Parse field 10 marks a hardware-loop end and leaves the packet open. Parse field 01 is a plain word that leaves the packet open.

When a packet closes, the block presents one registered result for one cycle. The result holds the ordered instruction list, the number of list entries, the number of words used and the packet size in bytes. The framer derives loop-end entries from the parse fields of the first two words and adds them at the tail of the list. If the input stream runs out before a closing word, or the word limit is reached first, the packet is rejected and reports zero words.

Each list entry is 37 bits wide, laid out as {kind[36:35], group[34:32], data[31:0]}. Entry k sits at `out_list[k*37 +: 37]`. Kind codes are 0 for empty, 1 for a whole word, 2 for a sub-instruction and 3 for a loop end. Group codes are L1=0, L2=1, S1=2, S2=3, A=4, and 7 for "none".

Top module: `pkt_word_framer`

## Requirements
- R1: A word whose parse field is 01, 10 or 11 produces one entry with kind 1, group 7 and data equal to the whole word. Entries follow word order.
- R2: A word whose parse field is 00 produces two kind-2 entries. The first holds word bits [28:16] and the second holds bits [12:0], each zero-extended to 32 bits. Such a word closes the packet.
- R3: The duplex class is {word[31:29], word[13]}. The table below gives the (second entry, first entry) groups for classes 0 to E. The first entry takes the second group of each pair. The table is 0:(L1,L1), 1:(L2,L1), 2:(L2,L2), 3:(A,A), 4:(L1,A), 5:(L2,A), 6:(S1,A), 7:(S2,A), 8:(S1,L1), 9:(S1,L2), A:(S1,S1), B:(S2,S1), C:(S2,L1), D:(S2,L2), E:(S2,S2).
- R4: A duplex of class F sets `out_illegal` and gives both of its entries group 7. Packets with no class-F duplex report `out_illegal` = 0.
- R5: A word with parse field 11 closes the packet. An accepted packet reports `out_words` = N words and `out_bytes` = 4*N.
- R6: In a two-word packet whose word 0 has parse field 10, one kind-3 entry with data 0 follows the other entries.
- R7: In a packet of three or more words, a loop-end entry is added based on the parse fields of words 0 and 1. Both at 10 gives data 2. Only word 1 at 10 gives data 1. Only word 0 at 10 gives data 0. Neither gives no entry. One-word packets never get a loop-end entry.
- R8: If `in_last` is high on an accepted word that does not close the packet, the result has `out_short` = 1, and words, bytes, count, list and illegal are all zero.
- R9: If MAXW words are accepted without a closing word, the packet is rejected the same way as in R8.
- R10: During reset `out_valid` and `in_ready` are 0.
- R11: The result appears in the cycle after the handshake of the closing word and lasts for exactly one cycle. `out_valid` is 0 in a cycle after one with no accepted word. Packets may follow each other with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Framer accepts a word |
| in_word | input | 32 | Instruction word |
| in_last | input | 1 | No further words follow this one |
| out_valid | output | 1 | Packet result valid for one cycle |
| out_short | output | 1 | Packet rejected: closing word never arrived |
| out_illegal | output | 1 | Packet contains a reserved duplex class |
| out_words | output | 3 | Words used (0 when rejected) |
| out_bytes | output | 5 | Packet size in bytes |
| out_count | output | 4 | Number of list entries |
| out_list | output | 333 | Nine 37-bit entries, entry 0 in the low bits |

## Verification
The bench sends every duplex class and checks both group codes. A swapped table row or a lookup on the wrong class bits would show up as a wrong group on some entry. It covers all four loop-end combinations, including the two-word case and a four-word packet that ends in a duplex. A design that mixed up words 0 and 1, or added a loop end to short packets, would give a wrong code or a wrong entry count. Rejections by `in_last` and by the word limit are each followed at once by a valid packet. A design that did not clear its word counter after closing a packet would corrupt that next packet.

// File: rtl/pwf_pkg.sv
package pwf_pkg;
  localparam int INSN_W = 32;
  localparam int SUB_W  = 13;

  localparam logic [1:0] PB_DUP  = 2'b00;
  localparam logic [1:0] PB_LOOP = 2'b10;
  localparam logic [1:0] PB_END  = 2'b11;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_WORD = 2'd1,
    K_SUB  = 2'd2,
    K_LOOP = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    G_L1 = 3'd0,
    G_L2 = 3'd1,
    G_S1 = 3'd2,
    G_S2 = 3'd3,
    G_A  = 3'd4,
    G_NA = 3'd7
  } grp_e;

  typedef struct packed {
    kind_e              kind;
    grp_e               grp;
    logic [INSN_W-1:0]  data;
  } entry_t;

  typedef struct packed {
    grp_e lo_grp;  // half in bits [12:0]
    grp_e hi_grp;  // half in bits [28:16]
  } gpair_t;

  function automatic gpair_t class_groups(input logic [3:0] cls);
    gpair_t g;
    case (cls)
      4'h0: g = '{G_L1, G_L1};
      4'h1: g = '{G_L2, G_L1};
      4'h2: g = '{G_L2, G_L2};
      4'h3: g = '{G_A,  G_A };
      4'h4: g = '{G_L1, G_A };
      4'h5: g = '{G_L2, G_A };
      4'h6: g = '{G_S1, G_A };
      4'h7: g = '{G_S2, G_A };
      4'h8: g = '{G_S1, G_L1};
      4'h9: g = '{G_S1, G_L2};
      4'hA: g = '{G_S1, G_S1};
      4'hB: g = '{G_S2, G_S1};
      4'hC: g = '{G_S2, G_L1};
      4'hD: g = '{G_S2, G_L2};
      4'hE: g = '{G_S2, G_S2};
      default: g = '{G_NA, G_NA};
    endcase
    return g;
  endfunction
endpackage

// File: rtl/pwf_split.sv
module pwf_split
  import pwf_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output entry_t            first_e,
  output entry_t            second_e,
  output logic              dup,
  output logic              bad_cls
);
  logic [3:0] cls;
  gpair_t     gp;

  always_comb begin
    cls      = {word[31:29], word[13]};
    gp       = class_groups(cls);
    dup      = (word[15:14] == PB_DUP);
    bad_cls  = dup && (cls == 4'hF);
    first_e  = '0;
    second_e = '0;
    if (dup) begin
      first_e.kind  = K_SUB;
      first_e.grp   = bad_cls ? G_NA : gp.hi_grp;
      first_e.data  = {{(INSN_W-SUB_W){1'b0}}, word[16 +: SUB_W]};
      second_e.kind = K_SUB;
      second_e.grp  = bad_cls ? G_NA : gp.lo_grp;
      second_e.data = {{(INSN_W-SUB_W){1'b0}}, word[0 +: SUB_W]};
    end else begin
      first_e.kind  = K_WORD;
      first_e.grp   = G_NA;
      first_e.data  = word;
    end
  end
endmodule

// File: rtl/pwf_pack.sv
module pwf_pack
  import pwf_pkg::*;
#(
  parameter  int MAXW = 4,
  localparam int NWW  = $clog2(MAXW + 1),
  localparam int NE   = 2 * MAXW + 1,
  localparam int CW   = $clog2(NE + 1)
) (
  input  entry_t           first_e  [MAXW],
  input  entry_t           second_e [MAXW],
  input  logic [MAXW-1:0]  dup,
  input  logic [NWW-1:0]   nwords,
  input  logic             lp0,
  input  logic             lp1,
  output entry_t           list [NE],
  output logic [CW-1:0]    count
);
  logic             has_loop;
  logic [INSN_W-1:0] loop_code;

  always_comb begin
    has_loop  = 1'b0;
    loop_code = '0;
    if (nwords == NWW'(2)) begin
      has_loop = lp0;
    end else if (nwords >= NWW'(3)) begin
      has_loop = lp0 | lp1;
      if (lp0 && lp1)  loop_code = INSN_W'(2);
      else if (lp1)    loop_code = INSN_W'(1);
    end
  end

  always_comb begin
    int pos;
    pos = 0;
    for (int k = 0; k < NE; k++) list[k] = '0;
    for (int i = 0; i < MAXW; i++) begin
      if (NWW'(i) < nwords) begin
        list[pos] = first_e[i];
        pos++;
        if (dup[i]) begin
          list[pos] = second_e[i];
          pos++;
        end
      end
    end
    if (has_loop) begin
      list[pos].kind = K_LOOP;
      list[pos].grp  = G_NA;
      list[pos].data = loop_code;
      pos++;
    end
    count = CW'(pos);
  end
endmodule

// File: rtl/pkt_word_framer.sv
module pkt_word_framer
  import pwf_pkg::*;
#(
  parameter  int MAXW = 4,
  localparam int NWW  = $clog2(MAXW + 1),
  localparam int NE   = 2 * MAXW + 1,
  localparam int EW   = $bits(entry_t),
  localparam int CW   = $clog2(NE + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSN_W-1:0]  in_word,
  input  logic               in_last,
  output logic               out_valid,
  output logic               out_short,
  output logic               out_illegal,
  output logic [NWW-1:0]     out_words,
  output logic [NWW+1:0]     out_bytes,
  output logic [CW-1:0]      out_count,
  output logic [NE*EW-1:0]   out_list
);
  logic [INSN_W-1:0] words_q [MAXW];
  logic [INSN_W-1:0] nxt     [MAXW];
  logic [NWW-1:0]    cnt_q;
  logic [NWW-1:0]    nwords;
  logic              rdy_q;

  entry_t            first_e  [MAXW];
  entry_t            second_e [MAXW];
  logic [MAXW-1:0]   dup;
  logic [MAXW-1:0]   bad;
  entry_t            list [NE];
  logic [CW-1:0]     count;
  logic              lp0, lp1;
  logic              illegal_any;
  logic              acc, end_w, full, close;

  assign in_ready = rdy_q;
  assign acc      = in_valid && rdy_q;
  assign nwords   = cnt_q + 1'b1;
  assign end_w    = (in_word[15:14] == PB_END) || (in_word[15:14] == PB_DUP);
  assign full     = (nwords == NWW'(MAXW));
  assign close    = acc && (end_w || in_last || full);

  // word window as it stands once the incoming word is added
  always_comb begin
    for (int i = 0; i < MAXW; i++)
      nxt[i] = (NWW'(i) == cnt_q) ? in_word : words_q[i];
  end

  for (genvar gi = 0; gi < MAXW; gi++) begin : g_split
    pwf_split u_split (
      .word     (nxt[gi]),
      .first_e  (first_e[gi]),
      .second_e (second_e[gi]),
      .dup      (dup[gi]),
      .bad_cls  (bad[gi])
    );
  end

  assign lp0 = (nxt[0][15:14] == PB_LOOP);
  if (MAXW > 1) begin : g_lp1
    assign lp1 = (nxt[1][15:14] == PB_LOOP);
  end else begin : g_no_lp1
    assign lp1 = 1'b0;
  end

  always_comb begin
    illegal_any = 1'b0;
    for (int i = 0; i < MAXW; i++)
      if (NWW'(i) < nwords && bad[i]) illegal_any = 1'b1;
  end

  pwf_pack #(.MAXW(MAXW)) u_pack (
    .first_e  (first_e),
    .second_e (second_e),
    .dup      (dup),
    .nwords   (nwords),
    .lp0      (lp0),
    .lp1      (lp1),
    .list     (list),
    .count    (count)
  );

  always_ff @(posedge clk) begin
    if (acc && !close) words_q[cnt_q] <= in_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q       <= 1'b0;
      cnt_q       <= '0;
      out_valid   <= 1'b0;
      out_short   <= 1'b0;
      out_illegal <= 1'b0;
      out_words   <= '0;
      out_bytes   <= '0;
      out_count   <= '0;
      out_list    <= '0;
    end else begin
      rdy_q     <= 1'b1;
      out_valid <= 1'b0;
      if (acc) begin
        if (close) begin
          cnt_q     <= '0;
          out_valid <= 1'b1;
          if (!end_w) begin
            out_short   <= 1'b1;
            out_illegal <= 1'b0;
            out_words   <= '0;
            out_bytes   <= '0;
            out_count   <= '0;
            out_list    <= '0;
          end else begin
            out_short   <= 1'b0;
            out_illegal <= illegal_any;
            out_words   <= nwords;
            out_bytes   <= {nwords, 2'b00};
            out_count   <= count;
            for (int k = 0; k < NE; k++) out_list[k*EW +: EW] <= list[k];
          end
        end else begin
          cnt_q <= nwords;
        end
      end
    end
  end
endmodule

// File: rtl/pwf_checks.sv
module pwf_checks #(
  parameter  int MAXW = 4,
  localparam int NWW  = $clog2(MAXW + 1),
  localparam int NE   = 2 * MAXW + 1,
  localparam int CW   = $clog2(NE + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [31:0]    in_word,
  input logic           in_last,
  input logic           out_valid,
  input logic           out_short,
  input logic [NWW-1:0] out_words,
  input logic [NWW+1:0] out_bytes,
  input logic [CW-1:0]  out_count
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_reject_empty_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_short |-> out_words == '0 && out_count == '0 && out_bytes == '0);

  p_bytes_words_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_short |-> out_bytes == {out_words, 2'b00} && out_words != '0);

  p_end_closes_r5: assert property (@(posedge clk) disable iff (rst)
    acc && in_word[15:14] == 2'b11 |=> out_valid && !out_short);

  p_dup_closes_r2: assert property (@(posedge clk) disable iff (rst)
    acc && in_word[15:14] == 2'b00 |=> out_valid && !out_short && out_count >= CW'(2));

  p_last_open_short_r8: assert property (@(posedge clk) disable iff (rst)
    acc && in_last && (in_word[15] ^ in_word[14]) |=> out_valid && out_short);

  p_no_result_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !out_valid);
endmodule

bind pkt_word_framer pwf_checks #(.MAXW(MAXW)) u_pwf_checks (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_word   (in_word),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_short (out_short),
  .out_words (out_words),
  .out_bytes (out_bytes),
  .out_count (out_count)
);

// File: tb/test_pkt_word_framer.sv
module test_pkt_word_framer;
  localparam int MAXW = 4;
  localparam int NE   = 9;
  localparam int EW   = 37;
  localparam int LW   = NE * EW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   in_word = '0;
  logic          in_last = 1'b0;
  logic          out_valid, out_short, out_illegal;
  logic [2:0]    out_words;
  logic [4:0]    out_bytes;
  logic [3:0]    out_count;
  logic [LW-1:0] out_list;

  always #2.5 clk = ~clk;  // 200 MHz

  pkt_word_framer #(.MAXW(MAXW)) i_pkt_word_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_last(in_last), .out_valid(out_valid),
    .out_short(out_short), .out_illegal(out_illegal), .out_words(out_words),
    .out_bytes(out_bytes), .out_count(out_count), .out_list(out_list)
  );

  typedef struct packed {
    logic          shrt;
    logic          ill;
    logic [2:0]    words;
    logic [4:0]    bytes;
    logic [3:0]    count;
    logic [LW-1:0] list;
  } exp_t;

  exp_t  sb[$];
  string tq[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  task automatic chk(input string tag, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // group pair {lo-half group, hi-half group} per class
  function automatic logic [5:0] grp_of(input logic [3:0] c);
    case (c)
      4'h0: return {3'd0, 3'd0};
      4'h1: return {3'd1, 3'd0};
      4'h2: return {3'd1, 3'd1};
      4'h3: return {3'd4, 3'd4};
      4'h4: return {3'd0, 3'd4};
      4'h5: return {3'd1, 3'd4};
      4'h6: return {3'd2, 3'd4};
      4'h7: return {3'd3, 3'd4};
      4'h8: return {3'd2, 3'd0};
      4'h9: return {3'd2, 3'd1};
      4'hA: return {3'd2, 3'd2};
      4'hB: return {3'd3, 3'd2};
      4'hC: return {3'd3, 3'd0};
      4'hD: return {3'd3, 3'd1};
      4'hE: return {3'd3, 3'd3};
      default: return {3'd7, 3'd7};
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] pb, input logic [31:0] b);
    return {b[31:16], pb, b[13:0]};
  endfunction

  function automatic logic [31:0] mkdup(input logic [3:0] c, input logic [12:0] hi,
                                        input logic [12:0] lo);
    return {c[3:1], hi, 2'b00, c[0], lo};
  endfunction

  function automatic exp_t model(input logic [31:0] w0, input logic [31:0] w1,
                                 input logic [31:0] w2, input logic [31:0] w3,
                                 input int n);
    exp_t        e;
    logic [31:0] w[4];
    logic [1:0]  pbl;
    logic [5:0]  g;
    logic [3:0]  c;
    bit          l0, l1;
    int          pos;
    w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
    e    = '0;
    pbl  = w[n-1][15:14];
    if (pbl == 2'b01 || pbl == 2'b10) begin
      e.shrt = 1'b1;
      return e;
    end
    pos = 0;
    for (int i = 0; i < n; i++) begin
      if (w[i][15:14] == 2'b00) begin
        c = {w[i][31:29], w[i][13]};
        g = grp_of(c);
        if (c == 4'hF) e.ill = 1'b1;
        e.list[pos*EW +: EW] = {2'd2, g[2:0], 19'd0, w[i][28:16]};
        pos++;
        e.list[pos*EW +: EW] = {2'd2, g[5:3], 19'd0, w[i][12:0]};
        pos++;
      end else begin
        e.list[pos*EW +: EW] = {2'd1, 3'd7, w[i]};
        pos++;
      end
    end
    l0 = (w[0][15:14] == 2'b10);
    l1 = (n > 1) && (w[1][15:14] == 2'b10);
    if (n == 2 && l0) begin
      e.list[pos*EW +: EW] = {2'd3, 3'd7, 32'd0}; pos++;
    end else if (n >= 3 && (l0 || l1)) begin
      e.list[pos*EW +: EW] = {2'd3, 3'd7, (l0 && l1) ? 32'd2 : (l1 ? 32'd1 : 32'd0)};
      pos++;
    end
    e.words = 3'(n);
    e.bytes = 5'(4 * n);
    e.count = 4'(pos);
    return e;
  endfunction

  task automatic send(input string tag, input logic [31:0] w0, input logic [31:0] w1,
                      input logic [31:0] w2, input logic [31:0] w3,
                      input int n, input bit lastf);
    logic [31:0] w[4];
    w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
    sb.push_back(model(w0, w1, w2, w3, n));
    tq.push_back(tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_word  = w[k];
      in_last  = lastf && (k == n - 1);
    end
  endtask

  task automatic idle(input int cyc);
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        chk("R11", "unexpected out_valid", LW'(1), LW'(0));
      end else begin
        exp_t  e;
        string t;
        e = sb.pop_front();
        t = tq.pop_front();
        chk(t, "out_short",   LW'(out_short),   LW'(e.shrt));
        chk(t, "out_illegal", LW'(out_illegal), LW'(e.ill));
        chk(t, "out_words",   LW'(out_words),   LW'(e.words));
        chk(t, "out_bytes",   LW'(out_bytes),   LW'(e.bytes));
        chk(t, "out_count",   LW'(out_count),   LW'(e.count));
        chk(t, "out_list",    out_list,         e.list);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "out_valid in reset", LW'(out_valid), LW'(0));
    chk("R10", "in_ready in reset",  LW'(in_ready),  LW'(0));
    @(negedge clk) rst = 1'b0;
    idle(2);

    // R1 R5: single closing word
    send("R1_R5 single", mk(2'b11, 32'h1234_5678), 0, 0, 0, 1, 0);
    idle(2);
    // R2: lone duplex, class 3
    send("R2 duplex", mkdup(4'h3, 13'h0ABC, 13'h1357), 0, 0, 0, 1, 0);
    idle(1);
    // R3: every legal class, back to back (R11)
    for (int c = 0; c < 15; c++)
      send("R3 class", mkdup(4'(c), 13'(c * 37 + 5), 13'(c * 91 + 2)), 0, 0, 0, 1, 0);
    idle(1);
    // R4: reserved class after a plain word
    send("R4 reserved", mk(2'b01, 32'hA5A5_0000), mkdup(4'hF, 13'h1FFF, 13'h0001), 0, 0, 2, 0);
    // R1: three plain words, no loop end
    send("R1 three", mk(2'b01, 32'h1111_1111), mk(2'b01, 32'h2222_2222),
         mk(2'b11, 32'h3333_3333), 0, 3, 0);
    // R6: two words, loop end on word 0
    send("R6 two loop0", mk(2'b10, 32'h0F0F_0F0F), mk(2'b11, 32'hF0F0_F0F0), 0, 0, 2, 0);
    // R6: two words ending in a duplex
    send("R6 two dup", mk(2'b10, 32'h7777_0000), mkdup(4'h9, 13'h0123, 13'h0456), 0, 0, 2, 0);
    // R7: combinations
    send("R7 both", mk(2'b10, 32'h1), mk(2'b10, 32'h2), mk(2'b11, 32'h3), 0, 3, 0);
    send("R7 word1", mk(2'b01, 32'h4), mk(2'b10, 32'h5), mk(2'b11, 32'h6), 0, 3, 0);
    send("R7 word0", mk(2'b10, 32'h7), mk(2'b01, 32'h8), mk(2'b11, 32'h9), 0, 3, 0);
    send("R7 four dup", mk(2'b10, 32'hAAAA_0000), mk(2'b10, 32'hBBBB_0000),
         mk(2'b01, 32'hCCCC_0000), mkdup(4'hE, 13'h1ABC, 13'h0DEF), 4, 0);
    idle(1);
    // R8: stream ends early, followed at once by a good packet
    send("R8 short", mk(2'b01, 32'hDEAD_0000), mk(2'b10, 32'hBEEF_0000), 0, 0, 2, 1);
    send("R8 after", mk(2'b11, 32'h5555_AAAA), 0, 0, 0, 1, 0);
    // R9: word limit reached without closing word
    send("R9 limit", mk(2'b01, 32'h1), mk(2'b10, 32'h2), mk(2'b01, 32'h3),
         mk(2'b10, 32'h4), 4, 0);
    send("R9 after", mk(2'b10, 32'h9999_0000), mk(2'b11, 32'h8888_0000), 0, 0, 2, 0);
    idle(3);
    chk("R11", "out_valid while idle", LW'(out_valid), LW'(0));
    chk("R11", "results pending", LW'(sb.size()), LW'(0));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule